// File: doc/BRIEF.md
# Register-Bus Bridge with Sticky Completion Flags

This block sits between a memory-mapped host port and an internal register bus. The host issues 64-bit read and write requests. The block folds the host byte address into a register index, using one of two formulas picked by a generation-select input. A small set of indices is answered on the spot by a built-in responder. These indices are identification, region bases and sizes, and a group of error, log, poll and fault registers. Every other access is forwarded to a downstream register port, which answers with an acknowledge and an error flag.

Each transaction ends with a one-cycle response pulse and read data. It also sets two sticky status bits, done and fail, which the host clears by writing ones. The host address port is exactly as wide as the bridge window, so an address is always taken modulo the window size. Data words pass through as big-endian 64-bit values: byte lane 0 sits on bits 63:56, and the bridge never swaps them. If the downstream port stays silent for longer than a programmable number of cycles, the transaction is abandoned as failed.

Top module: `regbus_bridge`

## Requirements
- R1: A request whose `host_size` is not 8, or whose `host_addr[2:0]` is not zero, is refused. It completes with done and fail set, read data 0, and nothing on the downstream port.
- R3: With `gen_sel`=1 the register index is the host address shifted right by 3.
- R4: With `gen_sel`=0 the index is ((addr>>4) with its low 4 bits cleared) OR ((addr>>3) AND 0xF), so address bit 7 has no effect.
- R5: A forwarded access drives `ds_addr` = index<<3, together with the request's write flag and its unmodified 64-bit data word.
- R6: Index 0x000F000F reads as the CHIP_ID parameter. Writes to it are dropped and never reach downstream.
- R7: These indices read as zero and drop writes: 0x000F0033/34, 0x00090012/13/18, 0x01010C00/03, 0x01020013/14, 0x02010828/2A/41/42, 0x02013028/2A, 0x02013801/02, 0x02020007/09/0F and 0x04010828/2A/41/42. Indices 0x01010C01/02/04/05 drop writes but forward reads. Indices 0x00018002 and 0x02013F01/03/05/07 read as zero but forward writes.
- R8: Reads of 0x02013F00 and 0x05012B00 return REG_A_BASE. Reads of 0x02013F04 and 0x05012B04 return REG_A_SIZE. Reads of 0x02013F02 and 0x05012B02 return REG_B_BASE. Reads of 0x02013F06 and 0x05012B06 return REG_B_SIZE. Writes to these eight indices are forwarded.
- R9: A completion without error sets done, and a read returns the local value or `ds_rdata`. A downstream error sets done and fail, and the read data is 0. Write responses carry data 0.
- R10: Done and fail are sticky. `st_clr[0]` clears done and `st_clr[1]` clears fail. A completion in the same cycle as a clear wins.
- R11: While a forwarded access is outstanding, `host_ready` is low, and `ds_req` stays high with a stable `ds_addr` until acknowledge or timeout.
- R12: An unanswered `ds_req` is held for max(`tmo_limit`,1) cycles, then dropped, and the transaction completes with done and fail. An acknowledge in the last allowed cycle still counts as success.
- R13: Refused and local accesses respond on the clock edge that accepts them. A forwarded access responds on the edge that samples `ds_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_sel | input | 1 | Address formula: 1 newer (shift by 3), 0 older (split fold) |
| tmo_limit | input | TW (8) | Downstream answer window in cycles |
| host_req | input | 1 | Host request valid |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | WIN_AW (35) | Host byte address inside the window |
| host_size | input | 4 | Access size in bytes |
| host_wdata | input | 64 | Write word, big-endian |
| host_ready | output | 1 | Bridge idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data of the completed access |
| st_clr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 fail |
| st_done | output | 1 | Sticky done flag |
| st_fail | output | 1 | Sticky fail flag |
| ds_req | output | 1 | Downstream request, held until answered |
| ds_we | output | 1 | Downstream write flag |
| ds_addr | output | WIN_AW (35) | Downstream address, index<<3 |
| ds_wdata | output | 64 | Downstream write word |
| ds_ack | input | 1 | Downstream answer |
| ds_err | input | 1 | Downstream error, valid with ds_ack |
| ds_rdata | input | 64 | Downstream read word, valid with ds_ack |

## Verification
Every locally handled index is swept with both a read and a write under each generation mode. This tells apart the read-local and write-drop classes, the half-local indices and the configured constants. A second sweep forwards 64 ordinary indices in each mode, with the older-mode address also issued with bit 7 set. The expected `ds_addr` and the returned word are derived from the index, so that sweep separates the two folding formulas and catches any dropped or misplaced index bit. Every invalid size and every misaligned low-address pattern is tried. Downstream delays, error replies and silent replies are applied against several window lengths, including an acknowledge landing exactly on the last allowed cycle. Clear patterns are applied to the sticky flags, including a clear issued in the same cycle as a completion.

// File: rtl/regbus_pkg.sv
// Shared types and the fixed register indices answered by the local responder.
// Assumes indices of at most 32 bits.
package regbus_pkg;

    typedef enum logic {
        BR_IDLE = 1'b0,
        BR_WAIT = 1'b1
    } br_state_e;

    localparam logic [3:0]  FULL_WORD_BYTES = 4'd8;

    localparam logic [31:0] IX_CHIP_ID      = 32'h000F_000F;

    localparam logic [31:0] IX_RGN_A_BASE_O = 32'h0201_3F00;
    localparam logic [31:0] IX_RGN_B_BASE_O = 32'h0201_3F02;
    localparam logic [31:0] IX_RGN_A_SIZE_O = 32'h0201_3F04;
    localparam logic [31:0] IX_RGN_B_SIZE_O = 32'h0201_3F06;
    localparam logic [31:0] IX_RGN_A_BASE_N = 32'h0501_2B00;
    localparam logic [31:0] IX_RGN_B_BASE_N = 32'h0501_2B02;
    localparam logic [31:0] IX_RGN_A_SIZE_N = 32'h0501_2B04;
    localparam logic [31:0] IX_RGN_B_SIZE_N = 32'h0501_2B06;

endpackage

// File: rtl/regbus_addr_fold.sv
// Folds a window byte address into a register index.
// gen_new=1: index = addr >> 3.
// gen_new=0: upper part from addr>>4 with the low nibble cleared, low nibble
// from addr>>3; address bit 7 drops out.
// Assumes WIN_AW >= 9. Address bits 2:0 are checked by the caller.
module regbus_addr_fold #(
    parameter int WIN_AW = 35,
    localparam int IW    = WIN_AW - 3
) (
    input  logic              gen_new,
    input  logic [WIN_AW-1:0] addr,
    output logic [IW-1:0]     idx
);

    logic [IW-1:0] idx_new;
    logic [IW-1:0] idx_old;

    // Both candidate indices, then a select by generation.
    always_comb begin
        idx_new = addr[WIN_AW-1:3];
        idx_old = {1'b0, addr[WIN_AW-1:8], addr[6:3]};
        idx     = gen_new ? idx_new : idx_old;
    end

endmodule

// File: rtl/regbus_local_resp.sv
// Built-in responder for the fixed index set.
// rd_hit/rd_val tell whether a read is answered locally and with what.
// wr_drop tells whether a write is swallowed without going downstream.
module regbus_local_resp
    import regbus_pkg::*;
#(
    parameter int          IW         = 32,
    parameter logic [63:0] CHIP_ID    = 64'h0,
    parameter logic [63:0] REG_A_BASE = 64'h0,
    parameter logic [63:0] REG_A_SIZE = 64'h0,
    parameter logic [63:0] REG_B_BASE = 64'h0,
    parameter logic [63:0] REG_B_SIZE = 64'h0
) (
    input  logic [IW-1:0] idx,
    output logic          rd_hit,
    output logic [63:0]   rd_val,
    output logic          wr_drop
);

    logic [31:0] ix;

    // Normalise the index to the width of the table constants.
    always_comb ix = 32'(idx);

    // Read side: constants, region descriptors and read-as-zero indices.
    always_comb begin
        rd_hit = 1'b1;
        rd_val = 64'h0;
        case (ix)
            IX_CHIP_ID:                       rd_val = CHIP_ID;
            IX_RGN_A_BASE_O, IX_RGN_A_BASE_N: rd_val = REG_A_BASE;
            IX_RGN_A_SIZE_O, IX_RGN_A_SIZE_N: rd_val = REG_A_SIZE;
            IX_RGN_B_BASE_O, IX_RGN_B_BASE_N: rd_val = REG_B_BASE;
            IX_RGN_B_SIZE_O, IX_RGN_B_SIZE_N: rd_val = REG_B_SIZE;
            32'h0001_8002,
            32'h0201_3F01, 32'h0201_3F03, 32'h0201_3F05, 32'h0201_3F07,
            32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
            32'h000F_0033, 32'h000F_0034,
            32'h0101_0C00, 32'h0101_0C03,
            32'h0102_0013, 32'h0102_0014,
            32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
            32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
            32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
            32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842:
                                              rd_val = 64'h0;
            default:                          rd_hit = 1'b0;
        endcase
    end

    // Write side: indices whose writes are swallowed.
    always_comb begin
        case (ix)
            IX_CHIP_ID,
            32'h0101_0C00, 32'h0101_0C01, 32'h0101_0C02,
            32'h0101_0C03, 32'h0101_0C04, 32'h0101_0C05,
            32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
            32'h000F_0033, 32'h000F_0034,
            32'h0102_0013, 32'h0102_0014,
            32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
            32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
            32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
            32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842:
                     wr_drop = 1'b1;
            default: wr_drop = 1'b0;
        endcase
    end

endmodule

// File: rtl/regbus_status.sv
// Sticky completion flags with write-one-to-clear.
// A set wins over a clear in the same cycle.
module regbus_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic [1:0] clr,
    output logic       done,
    output logic       fail
);

    // Done flag: set on any completion, cleared by clr[0].
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (set_done) done <= 1'b1;
        else if (clr[0])   done <= 1'b0;
    end

    // Fail flag: set on a failed completion, cleared by clr[1].
    always_ff @(posedge clk) begin
        if (!rst_n)        fail <= 1'b0;
        else if (set_fail) fail <= 1'b1;
        else if (clr[1])   fail <= 1'b0;
    end

endmodule

// File: rtl/regbus_bridge.sv
// Host-to-register-bus bridge.
// Accepts one request at a time while idle. Refused and locally answered
// requests complete on the accepting edge. Other requests are forwarded and
// held on the downstream port until acknowledged or until the answer window
// of max(tmo_limit,1) cycles ends.
// Assumes ds_err and ds_rdata are valid whenever ds_ack is high.
module regbus_bridge
    import regbus_pkg::*;
#(
    parameter int          WIN_AW     = 35,
    parameter int          TW         = 8,
    parameter logic [63:0] CHIP_ID    = 64'h0000_0000_220D_1049,
    parameter logic [63:0] REG_A_BASE = 64'h0000_0003_FFC0_0000,
    parameter logic [63:0] REG_A_SIZE = 64'h0000_0000_003F_0000,
    parameter logic [63:0] REG_B_BASE = 64'h0000_0003_FF80_0000,
    parameter logic [63:0] REG_B_SIZE = 64'h0000_0000_0070_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_sel,
    input  logic [TW-1:0]     tmo_limit,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [WIN_AW-1:0] host_addr,
    input  logic [3:0]        host_size,
    input  logic [63:0]       host_wdata,
    output logic              host_ready,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [1:0]        st_clr,
    output logic              st_done,
    output logic              st_fail,
    output logic              ds_req,
    output logic              ds_we,
    output logic [WIN_AW-1:0] ds_addr,
    output logic [63:0]       ds_wdata,
    input  logic              ds_ack,
    input  logic              ds_err,
    input  logic [63:0]       ds_rdata
);

    localparam int IW = WIN_AW - 3;

    br_state_e     state;
    logic [TW-1:0] wait_cnt;
    logic [IW-1:0] idx;
    logic          loc_rd_hit;
    logic          loc_wr_drop;
    logic [63:0]   loc_rd_val;

    logic accept, bad_req, is_local, imm_done, go_ds;
    logic expired, end_ack, end_tmo;
    logic cmp_now, cmp_fail;
    logic [63:0] cmp_data;

    regbus_addr_fold #(.WIN_AW(WIN_AW)) u_fold (
        .gen_new (gen_sel),
        .addr    (host_addr),
        .idx     (idx)
    );

    regbus_local_resp #(
        .IW         (IW),
        .CHIP_ID    (CHIP_ID),
        .REG_A_BASE (REG_A_BASE),
        .REG_A_SIZE (REG_A_SIZE),
        .REG_B_BASE (REG_B_BASE),
        .REG_B_SIZE (REG_B_SIZE)
    ) u_local (
        .idx     (idx),
        .rd_hit  (loc_rd_hit),
        .rd_val  (loc_rd_val),
        .wr_drop (loc_wr_drop)
    );

    regbus_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (cmp_now),
        .set_fail (cmp_fail),
        .clr      (st_clr),
        .done     (st_done),
        .fail     (st_fail)
    );

    // Ready whenever nothing is outstanding downstream.
    always_comb host_ready = (state == BR_IDLE);

    // Request classification at acceptance.
    always_comb begin
        accept   = host_req && host_ready;
        bad_req  = (host_size != FULL_WORD_BYTES) || (host_addr[2:0] != 3'b000);
        is_local = host_we ? loc_wr_drop : loc_rd_hit;
        imm_done = accept && (bad_req || is_local);
        go_ds    = accept && !bad_req && !is_local;
    end

    // End of a downstream wait: answer, or the window has run out.
    always_comb begin
        expired = ({1'b0, wait_cnt} + {{TW{1'b0}}, 1'b1}) >= {1'b0, tmo_limit};
        end_ack = (state == BR_WAIT) && ds_ack;
        end_tmo = (state == BR_WAIT) && !ds_ack && expired;
    end

    // Completion event, its fail flag and its read data.
    always_comb begin
        cmp_now  = imm_done || end_ack || end_tmo;
        cmp_fail = (imm_done && bad_req) || (end_ack && ds_err) || end_tmo;
        if (imm_done)
            cmp_data = (bad_req || host_we) ? 64'h0 : loc_rd_val;
        else if (end_ack)
            cmp_data = (ds_err || ds_we) ? 64'h0 : ds_rdata;
        else
            cmp_data = 64'h0;
    end

    // Transaction state and the wait-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BR_IDLE;
            wait_cnt <= '0;
        end else begin
            case (state)
                BR_IDLE: if (go_ds) begin
                    state    <= BR_WAIT;
                    wait_cnt <= '0;
                end
                BR_WAIT: if (end_ack || end_tmo) state <= BR_IDLE;
                         else                    wait_cnt <= wait_cnt + 1'b1;
                default: state <= BR_IDLE;
            endcase
        end
    end

    // Downstream request and its held address, write flag and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_req   <= 1'b0;
            ds_we    <= 1'b0;
            ds_addr  <= '0;
            ds_wdata <= '0;
        end else if (go_ds) begin
            ds_req   <= 1'b1;
            ds_we    <= host_we;
            ds_addr  <= {idx, 3'b000};
            ds_wdata <= host_wdata;
        end else if (end_ack || end_tmo) begin
            ds_req   <= 1'b0;
        end
    end

    // Host response pulse and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cmp_now;
            if (cmp_now) rsp_rdata <= cmp_data;
        end
    end

endmodule

// File: rtl/regbus_bridge_chk.sv
// Property checker for regbus_bridge, attached with bind.
// Counts the cycles of each downstream request to check the answer window.
module regbus_bridge_chk
    import regbus_pkg::*;
#(
    parameter int WIN_AW = 35,
    parameter int TW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TW-1:0]     tmo_limit,
    input logic              host_req,
    input logic              host_ready,
    input logic              rsp_valid,
    input logic [1:0]        st_clr,
    input logic              st_done,
    input logic              st_fail,
    input logic              ds_req,
    input logic              ds_ack,
    input logic [WIN_AW-1:0] ds_addr
);

    localparam logic [WIN_AW-1:0] CHIP_DS_ADDR = WIN_AW'({IX_CHIP_ID, 3'b000});

    logic [TW:0] run_q;
    logic [TW:0] lim_eff;

    // Effective window length: a limit of zero behaves as one.
    always_comb lim_eff = (tmo_limit == '0) ? {{TW{1'b0}}, 1'b1} : {1'b0, tmo_limit};

    // Number of earlier cycles in the current downstream request.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (ds_req) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> !host_ready);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && !ds_ack) |=> (!ds_req || $stable(ds_addr)));

    // R12
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> (run_q < lim_eff));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !st_clr[0]) |=> st_done);

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fail && !st_clr[1]) |=> st_fail);

    // R9
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_fail) |-> st_done);

    // R13
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(host_req && host_ready) || $past(ds_req)));

    // R6
    chip_id_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> (ds_addr != CHIP_DS_ADDR));

endmodule

bind regbus_bridge regbus_bridge_chk #(.WIN_AW(WIN_AW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_limit  (tmo_limit),
    .host_req   (host_req),
    .host_ready (host_ready),
    .rsp_valid  (rsp_valid),
    .st_clr     (st_clr),
    .st_done    (st_done),
    .st_fail    (st_fail),
    .ds_req     (ds_req),
    .ds_ack     (ds_ack),
    .ds_addr    (ds_addr)
);

// File: tb/regbus_bridge_bench.sv
// Self-checking bench: sweeps the local index set and the forwarding path in
// both generation modes, with expected values derived from the requirements.
module regbus_bridge_bench;

    localparam logic [63:0] P_CHIP = 64'h5A5A_0000_1234_C0DE;
    localparam logic [63:0] P_ABAS = 64'h0000_0007_7700_0000;
    localparam logic [63:0] P_ASIZ = 64'h0000_0000_0040_0000;
    localparam logic [63:0] P_BBAS = 64'h0000_0007_6600_0000;
    localparam logic [63:0] P_BSIZ = 64'h0000_0000_0080_0000;
    localparam logic [63:0] PAT    = 64'hC3A5_9600_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_sel = 1'b1;
    logic [7:0]  tmo_limit = 8'd20;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [34:0] host_addr = '0;
    logic [3:0]  host_size = 4'd8;
    logic [63:0] host_wdata = '0;
    logic        host_ready, rsp_valid, st_done, st_fail;
    logic [63:0] rsp_rdata;
    logic [1:0]  st_clr = 2'b00;
    logic        ds_req, ds_we;
    logic [34:0] ds_addr;
    logic [63:0] ds_wdata;
    logic        ds_ack = 1'b0, ds_err = 1'b0;
    logic [63:0] ds_rdata = '0;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Downstream model controls and observations
    int          m_dly = 0;
    bit          m_err = 1'b0, m_mute = 1'b0;
    int          dcnt = 0, txn = 0, hi = 0;
    logic [34:0] s_addr;
    logic        s_we;
    logic [63:0] s_wdata;

    always #5 clk = ~clk;

    regbus_bridge #(
        .WIN_AW(35), .TW(8), .CHIP_ID(P_CHIP),
        .REG_A_BASE(P_ABAS), .REG_A_SIZE(P_ASIZ),
        .REG_B_BASE(P_BBAS), .REG_B_SIZE(P_BSIZ)
    ) u_regbus_bridge (.*);

    // Downstream responder, acting between clock edges.
    always @(negedge clk) begin
        if (!ds_req) begin
            dcnt = 0; ds_ack = 1'b0;
        end else begin
            if (dcnt == 0) begin
                txn++; hi = 0; s_addr = ds_addr; s_we = ds_we; s_wdata = ds_wdata;
            end
            hi++;
            ds_ack   = !m_mute && (dcnt == m_dly);
            ds_err   = m_err;
            ds_rdata = ds_ack ? (PAT ^ 64'(ds_addr)) : 64'hDEAD_BEEF_DEAD_BEEF;
            dcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R3 / R4 index arithmetic
    function automatic logic [31:0] exp_idx(input bit g, input logic [34:0] a);
        logic [34:0] t;
        if (g) t = a >> 3;
        else   t = ((a >> 4) & ~35'hF) | ((a >> 3) & 35'hF);
        return t[31:0];
    endfunction

    function automatic logic [34:0] to_addr(input bit g, input logic [31:0] ix);
        if (g) return {ix, 3'b000};
        return 35'(ix & ~32'hF) << 4 | 35'(ix & 32'hF) << 3;
    endfunction

    // R6 R7 R8 read-side table
    function automatic bit rd_local(input logic [31:0] ix, output logic [63:0] v);
        v = 64'h0;
        case (ix)
            32'h000F_000F: begin v = P_CHIP; return 1'b1; end
            32'h0501_2B00, 32'h0201_3F00: begin v = P_ABAS; return 1'b1; end
            32'h0501_2B02, 32'h0201_3F02: begin v = P_BBAS; return 1'b1; end
            32'h0501_2B04, 32'h0201_3F04: begin v = P_ASIZ; return 1'b1; end
            32'h0501_2B06, 32'h0201_3F06: begin v = P_BSIZ; return 1'b1; end
            32'h0201_3F01, 32'h0201_3F03, 32'h0201_3F05, 32'h0201_3F07,
            32'h0001_8002: return 1'b1;
            default: return zero_both(ix);
        endcase
    endfunction

    function automatic bit zero_both(input logic [31:0] ix);
        case (ix)
            32'h0401_0842, 32'h0401_0841, 32'h0401_082A, 32'h0401_0828,
            32'h0201_0842, 32'h0201_0841, 32'h0201_082A, 32'h0201_0828,
            32'h0201_3802, 32'h0201_3801, 32'h0201_302A, 32'h0201_3028,
            32'h0202_000F, 32'h0202_0009, 32'h0202_0007,
            32'h0102_0014, 32'h0102_0013, 32'h0101_0C03, 32'h0101_0C00,
            32'h000F_0034, 32'h000F_0033,
            32'h0009_0018, 32'h0009_0013, 32'h0009_0012: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit wr_drop(input logic [31:0] ix);
        case (ix)
            32'h000F_000F, 32'h0101_0C01, 32'h0101_0C02,
            32'h0101_0C04, 32'h0101_0C05: return 1'b1;
            default: return zero_both(ix);
        endcase
    endfunction

    logic [31:0] special [42] = '{
        32'h000F_000F,
        32'h0009_0012, 32'h0009_0013, 32'h0009_0018, 32'h000F_0033, 32'h000F_0034,
        32'h0101_0C00, 32'h0101_0C03, 32'h0102_0013, 32'h0102_0014,
        32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
        32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
        32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
        32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842,
        32'h0101_0C01, 32'h0101_0C02, 32'h0101_0C04, 32'h0101_0C05,
        32'h0001_8002, 32'h0201_3F01, 32'h0201_3F03, 32'h0201_3F05, 32'h0201_3F07,
        32'h0201_3F00, 32'h0201_3F02, 32'h0201_3F04, 32'h0201_3F06,
        32'h0501_2B00, 32'h0501_2B02, 32'h0501_2B04, 32'h0501_2B06
    };

    task automatic clear_status();
        @(negedge clk); st_clr = 2'b11;
        @(negedge clk); st_clr = 2'b00;
    endtask

    // One host access with every expected value computed from the requirements.
    task automatic txn_chk(input string tag, input bit we, input logic [34:0] addr,
                           input logic [63:0] wd, input logic [3:0] sz);
        logic [31:0] ix;
        logic [63:0] lv, exp_rd;
        bit bad, loc, exp_fail, exp_ds, busy_ok;
        int exp_lat, lat, t0, lim_e;
        ix    = exp_idx(gen_sel, addr);
        bad   = (sz != 4'd8) || (addr[2:0] != 3'b000);
        loc   = we ? wr_drop(ix) : rd_local(ix, lv);
        lim_e = (tmo_limit == 0) ? 1 : int'(tmo_limit);
        exp_ds = !bad && !loc;
        if (bad) begin
            exp_lat = 0; exp_fail = 1'b1; exp_rd = 64'h0;
        end else if (loc) begin
            exp_lat = 0; exp_fail = 1'b0; exp_rd = we ? 64'h0 : lv;
        end else if (!m_mute && m_dly < lim_e) begin
            exp_lat = m_dly + 1; exp_fail = m_err;
            exp_rd = (we || m_err) ? 64'h0 : (PAT ^ 64'({ix, 3'b000}));
        end else begin
            exp_lat = lim_e; exp_fail = 1'b1; exp_rd = 64'h0;
        end
        clear_status();
        t0 = txn;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; host_size = sz;
        @(negedge clk);
        host_req = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (!rsp_valid && lat < 300) begin
            if (host_ready) busy_ok = 1'b0;
            @(negedge clk); lat++;
        end
        chk(lat == exp_lat, "R13", {tag, " latency"}, 64'(lat), 64'(exp_lat));
        chk(rsp_rdata == exp_rd, tag, "read data", rsp_rdata, exp_rd);
        chk(st_done == 1'b1, "R9", {tag, " done"}, 64'(st_done), 64'd1);
        chk(st_fail == exp_fail, "R9", {tag, " fail"}, 64'(st_fail), 64'(exp_fail));
        chk((txn - t0) == (exp_ds ? 1 : 0), tag, "downstream count",
            64'(txn - t0), 64'(exp_ds));
        if (exp_ds) begin
            chk(busy_ok, "R11", {tag, " ready low while busy"}, 64'(busy_ok), 64'd1);
            chk(s_addr == {ix, 3'b000}, "R5", {tag, " ds_addr"},
                64'(s_addr), 64'({ix, 3'b000}));
            chk(s_we == we, "R5", {tag, " ds_we"}, 64'(s_we), 64'(we));
            if (we) chk(s_wdata == wd, "R5", {tag, " ds_wdata"}, s_wdata, wd);
            if (exp_fail && (m_mute || m_dly >= lim_e))
                chk(hi == lim_e, "R12", {tag, " request length"}, 64'(hi), 64'(lim_e));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ix;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready && !st_done && !st_fail && !ds_req && !rsp_valid, "R10",
            "reset state", {59'd0, host_ready, st_done, st_fail, ds_req, rsp_valid},
            64'h10);

        // Local index sweep, both generations, reads and writes (R6 R7 R8)
        for (int g = 0; g < 2; g++) begin
            gen_sel = g[0];
            for (int k = 0; k < 42; k++) begin
                txn_chk("R7 local read", 1'b0, to_addr(gen_sel, special[k]), 64'h0, 4'd8);
                txn_chk("R8 local write", 1'b1, to_addr(gen_sel, special[k]),
                        64'h0102_0304_0506_0708 ^ 64'(k), 4'd8);
            end
            txn_chk("R6 chip id", 1'b0, to_addr(gen_sel, 32'h000F_000F), 64'h0, 4'd8);
        end

        // Forwarding sweep, new (R3) then old (R4) formula
        for (int g = 1; g >= 0; g--) begin
            gen_sel = g[0];
            for (int k = 0; k < 64; k++) begin
                ix = (32'(k) * 32'h0004_1231) ^ 32'h0300_0000 ^ 32'(k);
                if (!gen_sel) ix[31] = 1'b0;
                m_dly = k % 4;
                txn_chk(gen_sel ? "R3 forward" : "R4 forward", k[0],
                        to_addr(gen_sel, ix), {32'(k), ~32'(k)}, 4'd8);
                if (!gen_sel)
                    txn_chk("R4 bit7 alias", 1'b0, to_addr(gen_sel, ix) | 35'h80,
                            64'h0, 4'd8);
            end
        end
        m_dly = 0;

        // R1 sizes and alignment
        gen_sel = 1'b1;
        for (int s = 0; s < 16; s++)
            if (s != 8) txn_chk("R1 size", s[0], 35'h0_0123_4560, 64'h77, 4'(s));
        for (int a = 1; a < 8; a++)
            txn_chk("R1 misaligned", a[0], 35'h0_0123_4560 | 35'(a), 64'h77, 4'd8);

        // R9 downstream error on read and write
        m_err = 1'b1;
        txn_chk("R9 err read", 1'b0, 35'h0_0ABC_0000, 64'h0, 4'd8);
        txn_chk("R9 err write", 1'b1, 35'h0_0ABC_0008, 64'h55, 4'd8);
        m_err = 1'b0;

        // R12 timeouts and last-cycle acknowledge
        m_mute = 1'b1;
        for (int l = 0; l < 8; l += 3) begin
            tmo_limit = 8'(l);
            txn_chk("R12 timeout", 1'b0, 35'h0_0BCD_0000, 64'h0, 4'd8);
        end
        tmo_limit = 8'd1;
        txn_chk("R12 timeout one", 1'b1, 35'h0_0BCD_0010, 64'h9, 4'd8);
        m_mute = 1'b0;
        tmo_limit = 8'd4; m_dly = 3;
        txn_chk("R12 last-cycle ack", 1'b0, 35'h0_0BCD_0020, 64'h0, 4'd8);
        tmo_limit = 8'd20; m_dly = 0;

        // R10 separate clears after a failed access
        txn_chk("R10 setup", 1'b0, 35'h0_0000_0001, 64'h0, 4'd8);
        @(negedge clk); st_clr = 2'b01;
        @(negedge clk); st_clr = 2'b00;
        chk(!st_done && st_fail, "R10", "clear done only",
            {62'd0, st_done, st_fail}, 64'h1);
        @(negedge clk); st_clr = 2'b10;
        @(negedge clk); st_clr = 2'b00;
        chk(!st_done && !st_fail, "R10", "clear fail", {62'd0, st_done, st_fail}, 64'h0);

        // R10 completion wins over a clear on the same edge
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 35'h0_0000_0003; host_size = 4'd8;
        st_clr = 2'b11;
        @(negedge clk);
        host_req = 1'b0; st_clr = 2'b00;
        chk(rsp_valid && st_done && st_fail, "R10", "set beats clear",
            {61'd0, rsp_valid, st_done, st_fail}, 64'h7);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule